// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This block watches a two-wire bus from the slave side and keeps the status that a CPU needs to service it. SCL and SDA enter through multi-flop synchronizers. From the synchronized lines the block finds Start and Stop conditions, counts SCL rising edges into bytes and acknowledge slots, and compares each address byte with a programmable own address of 7 or 10 bits.

The status outputs are last-event indicators. They show whether a Start or a Stop was seen last, whether the last byte was address or data, and the direction bit from the last address match. In 10-bit mode a flag asks software to reload the address register. A buffer-full flag reports a received byte waiting for the CPU, or a byte loaded for transmission that has not yet been shifted out.

The block does not drive the bus. Acknowledge, clock stretching and pad control are handled elsewhere. The received byte is available on its own output.

Top module: `i2c_slave_status`

## Requirements
- R1: After reset every status output (start, stop, data, read, address-update, buffer-full) and the received byte are 0.
- R2: A Start is SDA falling while SCL is high, and a Stop is SDA rising while SCL is high, both seen after the synchronizers. A Start sets the start flag and clears the stop flag. A Stop sets the stop flag and clears the start flag. The two flags are never 1 together.
- R3: While `enable` is low, the start and stop flags are held at 0, bus conditions are ignored and byte tracking returns to idle.
- R4: In 7-bit mode, a first byte after a Start whose bits [7:1] equal `own_addr[6:0]` takes effect on its 8th SCL rising edge (bytes are MSB first). It sets buffer-full, sets the data flag to 0, loads the read flag with bit 0 (1 = read) and puts the byte on `rx_byte`.
- R5: In a write-addressed transfer each received data byte sets buffer-full and the data flag and updates `rx_byte` on its 8th SCL rising edge.
- R6: After a non-matching address the bytes that follow, up to the next Start or Stop, leave buffer-full and `rx_byte` unchanged.
- R7: A `buf_read` pulse clears buffer-full. A byte completion or a `tx_load` in the same cycle takes priority.
- R8: A `tx_load` pulse sets buffer-full. In a read-addressed transfer buffer-full stays 1 through bits 1 to 7 of the sent byte, drops on its 8th SCL rising edge, and the data flag becomes 1.
- R9: The read flag is cleared by a Start, by a Stop, and by a NACK (SDA high on the 9th SCL rising edge of a byte).
- R10: In 10-bit mode, a first byte equal to `{5'b11110, own_addr[9:8], 0}` and then a second byte equal to `own_addr[7:0]` each set the address-update flag and buffer-full, with the data flag at 0. After the second byte the read flag is 0. An `addr_wr` pulse clears the address-update flag.
- R11: In 10-bit mode, after a full write match and a repeated Start, a first byte `{5'b11110, own_addr[9:8], 1}` sets the read flag, the address-update flag and buffer-full. The same byte after a Stop and a fresh Start is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears the bus-condition flags |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| addr_10bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own slave address (bits [6:0] used in 7-bit mode) |
| buf_read | input | 1 | CPU read of the received byte (pulse) |
| tx_load | input | 1 | CPU load of a byte to send (pulse) |
| addr_wr | input | 1 | CPU write of the address register (pulse) |
| st_start | output | 1 | Start was the last bus condition |
| st_stop | output | 1 | Stop was the last bus condition |
| st_data | output | 1 | Last byte was data (1) or address (0) |
| st_read | output | 1 | Direction from the last address match, 1 = read |
| st_addr_upd | output | 1 | Software must load the next address byte |
| st_buf_full | output | 1 | Buffer full |
| rx_byte | output | 8 | Last received byte that counted |

## Verification
The bench builds the block with the default of two synchronizer stages. It holds every bus phase for six clocks, which leaves margin over the three-cycle path from a pin to a flag, so each check can sample a settled value. The own address 0x2B5 gives a high pair of 2'b10 and a low byte different from the high byte. This lets the 10-bit sequence exercise both comparisons, the repeated-Start read, and the read attempt after a Stop that must be refused. Random 7-bit transfers mix matching and foreign addresses with both directions and one to three bytes, so the ignore path and the NACK that ends a read both occur.

// File: rtl/i2c_slave_status.sv
module i2c_slave_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       addr_10bit,
  input  logic [9:0] own_addr,
  input  logic       buf_read,
  input  logic       tx_load,
  input  logic       addr_wr,
  output logic       st_start,
  output logic       st_stop,
  output logic       st_data,
  output logic       st_read,
  output logic       st_addr_upd,
  output logic       st_buf_full,
  output logic [7:0] rx_byte
);

  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR1, ST_ADDR2, ST_RX, ST_TX, ST_SKIP} state_t;

  logic [LAST:0] scl_sync, sda_sync;
  logic          scl_q, sda_q;
  state_t        state, nxt;
  logic [3:0]    bit_cnt;
  logic [6:0]    shreg;
  logic          hi_ok, hi_nxt;
  logic          hit, is_data, upd, rw_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[LAST-1:0], scl_in};
      sda_sync <= {sda_sync[LAST-1:0], sda_in};
      scl_q    <= scl_sync[LAST];
      sda_q    <= sda_sync[LAST];
    end

  wire scl_s     = scl_sync[LAST];
  wire sda_s     = sda_sync[LAST];
  wire scl_high  = scl_s & scl_q;
  wire start_det = enable & scl_high & sda_q & ~sda_s;
  wire stop_det  = enable & scl_high & ~sda_q & sda_s;
  wire bit_edge  = enable & scl_s & ~scl_q & (state != ST_IDLE);
  wire byte_end  = bit_edge & (bit_cnt == 4'd7);
  wire ack_edge  = bit_edge & (bit_cnt == 4'd8);

  wire [7:0] cur_byte = {shreg, sda_s};
  wire m7  = cur_byte[7:1] == own_addr[6:0];
  wire mhi = (cur_byte[7:3] == 5'b11110) && (cur_byte[2:1] == own_addr[9:8]);
  wire mlo = cur_byte == own_addr[7:0];

  always_comb begin
    hit     = 1'b0;
    is_data = 1'b0;
    upd     = 1'b0;
    rw_val  = 1'b0;
    hi_nxt  = hi_ok;
    nxt     = ST_SKIP;
    unique case (state)
      ST_ADDR1:
        if (!addr_10bit) begin
          if (m7) begin
            hit    = 1'b1;
            rw_val = cur_byte[0];
            nxt    = cur_byte[0] ? ST_TX : ST_RX;
          end
        end else if (mhi && !cur_byte[0]) begin
          hit = 1'b1;
          upd = 1'b1;
          nxt = ST_ADDR2;
        end else if (mhi && hi_ok) begin
          hit    = 1'b1;
          upd    = 1'b1;
          rw_val = 1'b1;
          nxt    = ST_TX;
        end else begin
          hi_nxt = 1'b0;
        end
      ST_ADDR2:
        if (mlo) begin
          hit    = 1'b1;
          upd    = 1'b1;
          hi_nxt = 1'b1;
          nxt    = ST_RX;
        end else begin
          hi_nxt = 1'b0;
        end
      ST_RX: begin
        hit     = 1'b1;
        is_data = 1'b1;
        nxt     = ST_RX;
      end
      ST_TX: begin
        is_data = 1'b1;
        nxt     = ST_TX;
      end
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      hi_ok    <= 1'b0;
      st_start <= 1'b0;
      st_stop  <= 1'b0;
      st_data  <= 1'b0;
      st_read  <= 1'b0;
      rx_byte  <= '0;
    end else if (!enable) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      st_start <= 1'b0;
      st_stop  <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR1;
      bit_cnt  <= '0;
      st_start <= 1'b1;
      st_stop  <= 1'b0;
      st_read  <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      hi_ok    <= 1'b0;
      st_start <= 1'b0;
      st_stop  <= 1'b1;
      st_read  <= 1'b0;
    end else if (bit_edge) begin
      if (ack_edge) begin
        bit_cnt <= '0;
        if (sda_s) begin
          st_read <= 1'b0;
          if (state == ST_TX) state <= ST_SKIP;
        end
      end else begin
        bit_cnt <= bit_cnt + 4'd1;
        shreg   <= {shreg[5:0], sda_s};
      end
      if (byte_end) begin
        state <= nxt;
        hi_ok <= hi_nxt;
        if (hit || state == ST_TX) st_data <= is_data;
        if (hit) rx_byte <= cur_byte;
        if (hit && !is_data) st_read <= rw_val;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          st_buf_full <= 1'b0;
    else if (tx_load)                    st_buf_full <= 1'b1;
    else if (byte_end && hit)            st_buf_full <= 1'b1;
    else if (byte_end && state == ST_TX) st_buf_full <= 1'b0;
    else if (buf_read)                   st_buf_full <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)               st_addr_upd <= 1'b0;
    else if (byte_end && upd) st_addr_upd <= 1'b1;
    else if (addr_wr)         st_addr_upd <= 1'b0;

endmodule

// File: rtl/i2c_slave_status_chk.sv
module i2c_slave_status_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tx_load,
  input logic buf_read,
  input logic addr_wr,
  input logic byte_end,
  input logic st_start,
  input logic st_stop,
  input logic st_read,
  input logic st_buf_full,
  input logic st_addr_upd
);

  assert_flag_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_start && st_stop));

  assert_disable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!st_start && !st_stop));

  assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_read && !tx_load && !byte_end) |=> !st_buf_full);

  assert_bf_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_buf_full) |-> $past(tx_load || byte_end));

  assert_start_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_start) |-> !st_read);

  assert_stop_rw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_stop) |-> !st_read);

  assert_upd_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !byte_end) |=> !st_addr_upd);

endmodule

bind i2c_slave_status i2c_slave_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tx_load(tx_load),
  .buf_read(buf_read), .addr_wr(addr_wr), .byte_end(byte_end),
  .st_start(st_start), .st_stop(st_stop), .st_read(st_read),
  .st_buf_full(st_buf_full), .st_addr_upd(st_addr_upd)
);

// File: tb/test_i2c_slave_status.sv
module test_i2c_slave_status;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic scl = 1'b1, sda = 1'b1, mode10 = 1'b0;
  logic buf_read = 1'b0, tx_load = 1'b0, addr_wr = 1'b0;
  logic [9:0] own = 10'h2B5;
  logic st_start, st_stop, st_data, st_read, st_addr_upd, st_buf_full;
  logic [7:0] rx_byte;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  i2c_slave_status i_i2c_slave_status (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl), .sda_in(sda),
    .addr_10bit(mode10), .own_addr(own), .buf_read(buf_read), .tx_load(tx_load),
    .addr_wr(addr_wr), .st_start(st_start), .st_stop(st_stop), .st_data(st_data),
    .st_read(st_read), .st_addr_upd(st_addr_upd), .st_buf_full(st_buf_full),
    .rx_byte(rx_byte)
  );

  function automatic logic hit7(logic [6:0] a, logic [9:0] o);
    return a == o[6:0];
  endfunction

  function automatic logic [7:0] hi_byte(logic [9:0] o, logic rd);
    return {5'b11110, o[9:8], rd};
  endfunction

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_bit(logic b);
    sda = b; wait_clk(Q); scl = 1'b1; wait_clk(Q); scl = 1'b0; wait_clk(Q);
  endtask
  task automatic bus_start;
    sda = 1'b1; wait_clk(Q); scl = 1'b1; wait_clk(Q); sda = 1'b0; wait_clk(Q); scl = 1'b0; wait_clk(Q);
  endtask
  task automatic bus_stop;
    sda = 1'b0; wait_clk(Q); scl = 1'b1; wait_clk(Q); sda = 1'b1; wait_clk(Q);
  endtask
  task automatic bus_byte(logic [7:0] v, int nbits);
    for (int i = 7; i > 7 - nbits; i--) bus_bit(v[i]);
  endtask
  task automatic pulse_read;  buf_read = 1'b1; wait_clk(1); buf_read = 1'b0; wait_clk(1); endtask
  task automatic pulse_load;  tx_load  = 1'b1; wait_clk(1); tx_load  = 1'b0; wait_clk(1); endtask
  task automatic pulse_addr;  addr_wr  = 1'b1; wait_clk(1); addr_wr  = 1'b0; wait_clk(1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_rx;
    void'($urandom(32'd4711));
    exp_rx = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(2);
    chk("R1 start", 32'(st_start), 0);
    chk("R1 stop", 32'(st_stop), 0);
    chk("R1 data", 32'(st_data), 0);
    chk("R1 read", 32'(st_read), 0);
    chk("R1 upd", 32'(st_addr_upd), 0);
    chk("R1 bf", 32'(st_buf_full), 0);
    chk("R1 rx", 32'(rx_byte), 0);
    enable = 1'b1;
    wait_clk(2);

    bus_start;
    chk("R2 start set", 32'(st_start), 1);
    enable = 1'b0;
    wait_clk(2);
    chk("R3 start cleared", 32'(st_start), 0);
    bus_stop;
    chk("R3 stop ignored", 32'(st_stop), 0);
    bus_start;
    chk("R3 start ignored", 32'(st_start), 0);
    enable = 1'b1;
    wait_clk(2);
    bus_stop;
    chk("R2 stop set", 32'(st_stop), 1);
    chk("R2 start clear", 32'(st_start), 0);

    for (int t = 0; t < 24; t++) begin
      logic [6:0] a;
      logic dir, hit;
      int n;
      logic [7:0] d;
      a   = ($urandom % 2 == 0) ? own[6:0] : 7'($urandom);
      dir = 1'($urandom);
      n   = 1 + int'($urandom % 3);
      hit = hit7(a, own);
      bus_start;
      chk("R2 start", 32'(st_start), 1);
      chk("R2 stop", 32'(st_stop), 0);
      bus_byte({a, dir}, 8);
      if (hit) begin
        exp_rx = {a, dir};
        chk("R4 bf", 32'(st_buf_full), 1);
        chk("R4 data", 32'(st_data), 0);
        chk("R4 read", 32'(st_read), 32'(dir));
        chk("R4 rx", 32'(rx_byte), 32'(exp_rx));
      end else begin
        chk("R6 bf", 32'(st_buf_full), 0);
        chk("R6 rx", 32'(rx_byte), 32'(exp_rx));
      end
      pulse_read;
      chk("R7 bf cleared", 32'(st_buf_full), 0);
      bus_bit(!hit);
      if (hit && dir) begin
        for (int k = 0; k < n; k++) begin
          d = 8'($urandom);
          pulse_load;
          chk("R8 bf load", 32'(st_buf_full), 1);
          bus_byte(d, 7);
          chk("R8 bf held", 32'(st_buf_full), 1);
          bus_bit(d[0]);
          chk("R8 bf drop", 32'(st_buf_full), 0);
          chk("R8 data", 32'(st_data), 1);
          chk("R9 read before nack", 32'(st_read), 1);
          bus_bit(k == n - 1);
        end
        chk("R9 read after nack", 32'(st_read), 0);
      end else begin
        for (int k = 0; k < n; k++) begin
          d = 8'($urandom);
          bus_byte(d, 8);
          if (hit) begin
            exp_rx = d;
            chk("R5 bf", 32'(st_buf_full), 1);
            chk("R5 data", 32'(st_data), 1);
            chk("R5 rx", 32'(rx_byte), 32'(exp_rx));
          end else begin
            chk("R6 bf", 32'(st_buf_full), 0);
            chk("R6 rx", 32'(rx_byte), 32'(exp_rx));
          end
          pulse_read;
          bus_bit(k == n - 1);
        end
      end
      bus_stop;
      chk("R2 stop", 32'(st_stop), 1);
      chk("R9 read after stop", 32'(st_read), 0);
    end

    mode10 = 1'b1;
    bus_start;
    bus_byte(hi_byte(own, 1'b0), 8);
    chk("R10 upd hi", 32'(st_addr_upd), 1);
    chk("R10 bf hi", 32'(st_buf_full), 1);
    chk("R10 data hi", 32'(st_data), 0);
    pulse_addr;
    chk("R10 upd clear", 32'(st_addr_upd), 0);
    pulse_read;
    bus_bit(1'b0);
    bus_byte(own[7:0], 8);
    chk("R10 upd lo", 32'(st_addr_upd), 1);
    chk("R10 bf lo", 32'(st_buf_full), 1);
    chk("R10 read lo", 32'(st_read), 0);
    chk("R10 rx lo", 32'(rx_byte), 32'(own[7:0]));
    pulse_addr;
    pulse_read;
    bus_bit(1'b0);
    bus_byte(8'h3C, 8);
    chk("R5 data 10b", 32'(st_data), 1);
    chk("R5 rx 10b", 32'(rx_byte), 32'h3C);
    pulse_read;
    bus_bit(1'b0);
    bus_start;
    chk("R9 read at restart", 32'(st_read), 0);
    bus_byte(hi_byte(own, 1'b1), 8);
    chk("R11 read", 32'(st_read), 1);
    chk("R11 upd", 32'(st_addr_upd), 1);
    chk("R11 bf", 32'(st_buf_full), 1);
    chk("R11 data", 32'(st_data), 0);
    pulse_addr;
    pulse_read;
    bus_bit(1'b0);
    pulse_load;
    bus_byte(8'hA7, 7);
    chk("R8 bf held 10b", 32'(st_buf_full), 1);
    bus_bit(1'b1);
    chk("R8 bf drop 10b", 32'(st_buf_full), 0);
    bus_bit(1'b1);
    chk("R9 read nack 10b", 32'(st_read), 0);
    bus_stop;
    bus_start;
    bus_byte(hi_byte(own, 1'b1), 8);
    chk("R11 refused read", 32'(st_read), 0);
    chk("R11 refused bf", 32'(st_buf_full), 0);
    chk("R11 refused upd", 32'(st_addr_upd), 0);
    bus_bit(1'b1);
    bus_stop;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule